// File: doc/BRIEF.md
# Bus Ready Merge

This block produces the one ready flag that the bus state machine samples on each rising clock edge to decide whether the current bus cycle finishes or gets another wait state. It accepts two ready sources. The first is a synchronous ready line that the system must already hold stable around the rising edge, so it goes to the output with no register in its path. The second is an asynchronous ready line that may change at any time. It is captured on the falling clock edge and then re-registered on the rising edge, so that it is safe to use half a clock period later.

A configuration input can give the synchronous ready pin to general-purpose I/O. In that mode the internal synchronous ready is forced low, and readiness then comes from the asynchronous path alone. Tying the synchronous line high makes every cycle ready. Tying it low gives full control to the asynchronous line. The output is the OR of the two paths.

Top module: `bus_ready_merge`

## Requirements
- R1: While rst_ni is low, the asynchronous path reads as not-ready, so ready_o equals the gated synchronous ready and ardy_i has no effect. Asserting rst_ni clears a pending asynchronous ready at once, without waiting for a clock edge.
- R2: With srdy_is_gpio_i = 0 and srdy_i = 1, ready_o is 1 in the same cycle, with no clock edge in between, whatever the value of ardy_i.
- R3: With srdy_is_gpio_i = 1, srdy_i has no effect on ready_o.
- R4: With the gated synchronous ready at 0, ready_o equals the synchronized asynchronous ready and nothing else.
- R5: ardy_i is captured on the falling clock edge. The captured value reaches ready_o after the next rising edge and not before it, and it stays there for one full clock period.
- R6: A change on ardy_i that arrives after a falling edge has no effect at the next rising edge. It first appears after the rising edge that follows the next falling edge.
- R7: ready_o is the logical OR of the gated synchronous ready and the synchronized asynchronous ready. The bench vector encoding is {srdy_is_gpio_i, ardy_i, srdy_i}, bit 2 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; rising edge is the sampling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| srdy_i | input | 1 | Synchronous ready, active high |
| ardy_i | input | 1 | Asynchronous ready, active high |
| srdy_is_gpio_i | input | 1 | 1 gives the synchronous ready pin to general-purpose I/O |
| ready_o | output | 1 | Combined ready flag for the bus state machine |

## Verification
A corrupted falling-edge stage shows up as a wrong ready_o value after the very next rising edge, because that edge copies the stage straight to the output. A rising-edge stage that holds a stale value keeps ready_o wrong for exactly one cycle, and the mistake is visible only while the gated synchronous ready is low, since a high synchronous ready hides it through the OR. A gate that leaks srdy_i in I/O mode, or a wrong combining term, changes ready_o with no clock edge in between. For that reason the bench checks between edges as well as after them, and it sweeps every pair of consecutive input vectors.

// File: rtl/brm_pkg.sv
package brm_pkg;
  typedef enum logic {
    PIN_READY = 1'b0,
    PIN_GPIO  = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/brm_ardy_sync.sv
module brm_ardy_sync #(
  parameter int unsigned RISE_STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ardy_i,
  output logic fall_o,
  output logic first_rise_o,
  output logic sync_o
);
  localparam int unsigned LAST = RISE_STAGES - 1;

  logic                   fall_q;
  logic [RISE_STAGES-1:0] rise_q;

  // half-period capture stage
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else         fall_q <= ardy_i;
  end

  for (genvar i = 0; i < RISE_STAGES; i++) begin : g_rise
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rise_q[i] <= 1'b0;
        else         rise_q[i] <= fall_q;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rise_q[i] <= 1'b0;
        else         rise_q[i] <= rise_q[i-1];
      end
    end
  end

  assign fall_o       = fall_q;
  assign first_rise_o = rise_q[0];
  assign sync_o       = rise_q[LAST];
endmodule

// File: rtl/brm_srdy_gate.sv
module brm_srdy_gate
  import brm_pkg::*;
(
  input  logic      srdy_i,
  input  pin_mode_e mode_i,
  output logic      srdy_o
);
  always_comb begin
    unique case (mode_i)
      PIN_GPIO: srdy_o = 1'b0;
      default:  srdy_o = srdy_i;
    endcase
  end
endmodule

// File: rtl/brm_combine.sv
module brm_combine (
  input  logic srdy_eff_i,
  input  logic ardy_sync_i,
  output logic ready_o
);
  assign ready_o = srdy_eff_i | ardy_sync_i;
endmodule

// File: rtl/bus_ready_merge.sv
module bus_ready_merge
  import brm_pkg::*;
#(
  parameter int unsigned RISE_STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srdy_i,
  input  logic ardy_i,
  input  logic srdy_is_gpio_i,
  output logic ready_o
);
  logic      fall_q;
  logic      rise0_q;
  logic      ardy_sync;
  logic      srdy_eff;
  pin_mode_e pin_mode;

  assign pin_mode = pin_mode_e'(srdy_is_gpio_i);

  brm_ardy_sync #(.RISE_STAGES(RISE_STAGES)) u_ardy_sync (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ardy_i       (ardy_i),
    .fall_o       (fall_q),
    .first_rise_o (rise0_q),
    .sync_o       (ardy_sync)
  );

  brm_srdy_gate u_srdy_gate (
    .srdy_i (srdy_i),
    .mode_i (pin_mode),
    .srdy_o (srdy_eff)
  );

  brm_combine u_combine (
    .srdy_eff_i  (srdy_eff),
    .ardy_sync_i (ardy_sync),
    .ready_o     (ready_o)
  );
endmodule

// File: rtl/brm_checker.sv
module brm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic srdy_i,
  input logic srdy_is_gpio_i,
  input logic ready_o,
  input logic fall_q,
  input logic rise0_q,
  input logic ardy_sync
);
  // R1: the asynchronous path is held clear during reset
  assert_reset_clears_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!ardy_sync && !fall_q));

  // R2: a high synchronous ready in pin mode forces ready
  assert_srdy_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srdy_i && !srdy_is_gpio_i) |-> ready_o);

  // R3: in I/O mode only the asynchronous path counts
  assert_gpio_masks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srdy_is_gpio_i |-> (ready_o == ardy_sync));

  // R4: with synchronous ready low the output follows the async path
  assert_ardy_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srdy_i |-> (ready_o == ardy_sync));

  // R5: the first rising stage takes what the falling stage held
  assert_half_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise0_q == $past(fall_q));

  // R7: no ready without a source
  assert_or_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ((srdy_i && !srdy_is_gpio_i) || ardy_sync));
endmodule

bind bus_ready_merge brm_checker u_brm_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .srdy_i         (srdy_i),
  .srdy_is_gpio_i (srdy_is_gpio_i),
  .ready_o        (ready_o),
  .fall_q         (fall_q),
  .rise0_q        (rise0_q),
  .ardy_sync      (ardy_sync)
);

// File: tb/bus_ready_merge_bench.sv
module bus_ready_merge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic srdy_i;
  logic ardy_i;
  logic srdy_is_gpio_i;
  logic ready_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_ready_merge u_bus_ready_merge (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .srdy_i         (srdy_i),
    .ardy_i         (ardy_i),
    .srdy_is_gpio_i (srdy_is_gpio_i),
    .ready_o        (ready_o)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (ready_o !== exp) begin
      errors++;
      $display("FAIL %s t=%0t ready_o=%b expected=%b", req, $time, ready_o, exp);
    end
  endtask

  // vector encoding {gpio, ardy, srdy}
  task automatic apply(input logic [2:0] v);
    srdy_i         = v[0];
    ardy_i         = v[1];
    srdy_is_gpio_i = v[2];
  endtask

  function automatic logic gated(input logic [2:0] v);
    return v[0] & ~v[2];
  endfunction

  task automatic to_rise;
    @(posedge clk_i); #2;
  endtask

  task automatic to_fall;
    @(negedge clk_i); #2;
  endtask

  initial begin
    rst_ni = 1'b0;
    apply(3'b010);
    repeat (3) @(posedge clk_i);
    #2;
    check("R1 ardy ignored in reset", 1'b0);
    apply(3'b011);
    #1;
    check("R1 srdy passes in reset", 1'b1);
    apply(3'b110);
    #1;
    check("R1 gpio in reset", 1'b0);
    apply(3'b000);
    to_rise();
    rst_ni = 1'b1;
    to_rise();
    check("R1 idle after release", 1'b0);

    // R7 exhaustive sweep over consecutive vector pairs
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 8; c++) begin
        apply(3'(p));
        to_rise();
        check("R7 prev vector settled", gated(3'(p)) | p[1]);
        apply(3'(c));
        #1;
        if (c[2]) check("R3 srdy masked in gpio", p[1]);
        else if (c[0]) check("R2 same-cycle srdy", 1'b1);
        else check("R4 async only", p[1]);
        to_rise();
        check("R7 cur vector settled", gated(3'(c)) | c[1]);
      end
    end

    // R5: captured on falling edge, visible only after next rising edge
    apply(3'b000);
    to_rise(); to_rise();
    ardy_i = 1'b1;
    to_fall();
    check("R5 not visible after falling edge", 1'b0);
    #2;
    check("R5 not visible before rising edge", 1'b0);
    to_rise();
    check("R5 visible after rising edge", 1'b1);
    ardy_i = 1'b0;
    to_rise();
    check("R5 cleared", 1'b0);

    // R5: pulse spanning only one falling edge lasts one full period
    ardy_i = 1'b1;
    to_fall();
    ardy_i = 1'b0;
    to_rise();
    check("R5 pulse seen", 1'b1);
    to_fall();
    check("R5 pulse held mid-cycle", 1'b1);
    to_rise();
    check("R5 pulse gone", 1'b0);

    // R6: change after falling edge waits for the following pair of edges
    to_fall();
    ardy_i = 1'b1;
    to_rise();
    check("R6 late change not seen", 1'b0);
    to_rise();
    check("R6 late change seen", 1'b1);

    // R3 in gpio mode: srdy toggling does not change the async result
    srdy_is_gpio_i = 1'b1;
    ardy_i = 1'b0;
    srdy_i = 1'b1;
    to_rise(); to_rise();
    check("R3 gpio srdy high ignored", 1'b0);
    srdy_i = 1'b0;
    #1;
    check("R3 gpio srdy low ignored", 1'b0);

    // R1: reset in mid-run clears the pending async ready at once
    apply(3'b010);
    to_rise(); to_rise();
    check("R1 async ready before reset", 1'b1);
    rst_ni = 1'b0;
    #1;
    check("R1 async clear on reset", 1'b0);
    to_rise();
    check("R1 held clear in reset", 1'b0);
    apply(3'b000);
    rst_ni = 1'b1;
    to_rise();
    check("R1 clear after second release", 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired ready_o=%b expected=completion", ready_o);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule